// File: doc/BRIEF.md
# Interrupt Vector Priority Controller

This block sits between a set of interrupt request lines and the fetch logic of a small processor core. It decides which request is serviced next and supplies that request's vector address in program memory. Each request is captured on its rising edge into a pending flag. Each interrupt line has its own enable bit, and all interrupt lines share one global enable flag. A reset request always occupies vector slot 0 and bypasses every mask. Slot numbers then rise with the interrupt line number, and a lower slot always wins over a higher one. A boot-protection lock input, combined with the current program counter, can hold off all interrupts while execution is inside the protected boot region.

The chosen vector is handed to the core on a valid/ready interface. Once the block raises `vec_valid`, the offer holds the same index and address until the core takes it with `vec_ready`. Back-pressure only delays acceptance and never drops a pending request. There is one exception: a reset request replaces an interrupt offer that is still waiting. When the core accepts an offer, the block does three things. It clears the global enable. It clears the winner's pending flag. In the next cycle it pulses that source's acknowledge line for one cycle. The core drives `gie_restore` when the interrupt routine returns, and this sets the global enable again.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A pending flag sets on a 0-to-1 transition of its request line, including a line already high at the first clock after reset. The flag stays set until its vector is accepted, even while the source is masked. A request held high after acceptance does not set the flag again.
- R2: Interrupt line i is a candidate only while `irq_en[i]` is 1 and the global enable `gie` is 1.
- R3: Slot 0 is reset and interrupt line i is slot i+1. Among candidates, the lowest slot is offered on `vec_idx`.
- R4: `vec_addr` equals VEC_BASE + 2 × `vec_idx`, since each slot is two words wide.
- R5: A reset request is offered whatever `gie`, the enables and the lock input are set to. It replaces an interrupt offer that has not been accepted yet.
- R6: While `boot_lock` is 1 and `pc` ≥ BOOT_START, no interrupt slot is offered. Below BOOT_START, or with `boot_lock` at 0, the lock has no effect.
- R7: While `vec_valid` is 1 and `vec_ready` is 0, the offer keeps its index in the next cycle. The only exception is the change to slot 0 required by R5. A vector is accepted in a cycle where `vec_valid` and `vec_ready` are both 1.
- R8: Acceptance does three things. It clears `gie` and drops `vec_valid` in the next cycle. It clears the winner's pending flag. It raises exactly one acknowledge line (`rst_ack` for slot 0, otherwise `irq_ack[slot-1]`) for exactly one cycle.
- R9: `gie_restore` sets `gie` to 1 in the next cycle, unless an acceptance happens in the same cycle, in which case the clear wins.
- R10: After reset, `vec_valid`, `gie`, `rst_ack` and `irq_ack` are all 0.
- R11: A request rising before clock edge n is offered after edge n+1, not after edge n. There is one cycle of latching and one cycle of offer registration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset request line (slot 0) |
| irq_req | input | NUM_SRC | Interrupt request lines |
| irq_en | input | NUM_SRC | Per-line enable bits |
| gie_restore | input | 1 | Sets the global enable (return from interrupt) |
| boot_lock | input | 1 | Boot-protection lock |
| pc | input | PC_W | Current program counter |
| vec_valid | output | 1 | A vector is offered |
| vec_ready | input | 1 | Core takes the offered vector |
| vec_idx | output | IDX_W | Offered slot number |
| vec_addr | output | PC_W | Offered vector address |
| irq_ack | output | NUM_SRC | One-cycle acknowledge per interrupt line |
| rst_ack | output | 1 | One-cycle acknowledge of the reset slot |
| gie | output | 1 | Global interrupt enable flag |

## Verification
The bench sweeps every combination of request pattern and enable mask on a four-line configuration. In each case it checks the first winner, the acknowledge line and then the runner-up after a restore. A design that picks the highest slot, ignores an enable, or lets a still-high line re-trigger offers the wrong slot. It also targets the cases at the edges of the masks. One is reset arriving while interrupts are masked or locked, or while an interrupt offer is stalled; a design without preemption keeps offering the interrupt slot. Another is the lock at the program-counter values just below and at the boot start; an off-by-one comparison offers or blocks at the wrong one. A third is a short pulse on a masked line; a design that gates the pending latch with the enable loses it. The bench also samples the exact cycle of the first offer and the single-cycle acknowledge, so an extra or missing register shows up.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // Bits needed to number the reset slot plus n_src interrupt slots.
  function automatic int idx_width(input int n_src);
    return (n_src + 1 <= 2) ? 1 : $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] req_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[g] <= 1'b0;
        pend[g]  <= 1'b0;
      end else begin
        req_q[g] <= req[g];
        // A new edge in the acceptance cycle survives the clear.
        if (req[g] && !req_q[g]) pend[g] <= 1'b1;
        else if (clr[g])         pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_region_gate.sv
module irq_region_gate #(
  parameter int              PC_W       = 13,
  parameter logic [PC_W-1:0] BOOT_START = '1
) (
  input  logic            lock,
  input  logic [PC_W-1:0] pc,
  output logic            block
);
  always_comb block = lock && (pc >= BOOT_START);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int W     = 9,
  parameter int IDX_W = 4
) (
  input  logic [W-1:0]     cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so the lowest set slot is written last.
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
    any = |cand;
  end
endmodule

// File: rtl/irq_offer_stage.sv
module irq_offer_stage #(
  parameter int W     = 9,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     cand,
  input  logic             any,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             ready,
  input  logic             restore,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     clr,
  output logic [W-1:0]     ack,
  output logic             gie
);
  logic fire;
  logic preempt;
  logic [W-1:0] win_hot;

  always_comb begin
    fire    = valid && ready;
    preempt = valid && !fire && cand[0] && (idx != '0);
    win_hot = W'(1) << idx;
    clr     = fire ? win_hot : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      idx   <= '0;
      ack   <= '0;
      gie   <= 1'b0;
    end else begin
      ack <= fire ? win_hot : '0;
      if (fire) begin
        valid <= 1'b0;
      end else if (!valid && any) begin
        valid <= 1'b1;
        idx   <= pick_idx;
      end else if (preempt) begin
        idx <= '0;
      end
      if (fire)         gie <= 1'b0;
      else if (restore) gie <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_vec_pkg::*;
#(
  parameter int              NUM_SRC    = 8,
  parameter int              PC_W       = 13,
  parameter logic [PC_W-1:0] VEC_BASE   = '0,
  parameter logic [PC_W-1:0] BOOT_START = 13'h1C00,
  localparam int             W          = NUM_SRC + 1,
  localparam int             IDX_W      = idx_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_req,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               gie_restore,
  input  logic               boot_lock,
  input  logic [PC_W-1:0]    pc,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [IDX_W-1:0]   vec_idx,
  output logic [PC_W-1:0]    vec_addr,
  output logic [NUM_SRC-1:0] irq_ack,
  output logic               rst_ack,
  output logic               gie
);
  logic [W-1:0]     pend;
  logic [W-1:0]     clr;
  logic [W-1:0]     ack;
  logic [W-1:0]     cand;
  logic             block;
  logic             any;
  logic [IDX_W-1:0] pick_idx;

  irq_edge_latch #(.W(W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .req  ({irq_req, reset_req}),
    .clr  (clr),
    .pend (pend)
  );

  irq_region_gate #(.PC_W(PC_W), .BOOT_START(BOOT_START)) u_gate (
    .lock (boot_lock),
    .pc   (pc),
    .block(block)
  );

  // Slot 0 ignores every mask; interrupt slots need enable, gie and no lock.
  always_comb begin
    cand[0] = pend[0];
    cand[W-1:1] = pend[W-1:1] & irq_en & {NUM_SRC{gie && !block}};
  end

  irq_prio_pick #(.W(W), .IDX_W(IDX_W)) u_pick (
    .cand(cand),
    .any (any),
    .idx (pick_idx)
  );

  irq_offer_stage #(.W(W), .IDX_W(IDX_W)) u_offer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (cand),
    .any     (any),
    .pick_idx(pick_idx),
    .ready   (vec_ready),
    .restore (gie_restore),
    .valid   (vec_valid),
    .idx     (vec_idx),
    .clr     (clr),
    .ack     (ack),
    .gie     (gie)
  );

  always_comb begin
    vec_addr = VEC_BASE + (PC_W'(vec_idx) << 1);
    rst_ack  = ack[0];
    irq_ack  = ack[W-1:1];
  end
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
  parameter int              NUM_SRC    = 8,
  parameter int              PC_W       = 13,
  parameter logic [PC_W-1:0] BOOT_START = 13'h1C00,
  parameter int              IDX_W      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gie_restore,
  input logic               boot_lock,
  input logic [PC_W-1:0]    pc,
  input logic               vec_valid,
  input logic               vec_ready,
  input logic [IDX_W-1:0]   vec_idx,
  input logic [NUM_SRC-1:0] irq_ack,
  input logic               rst_ack,
  input logic               gie
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && ($stable(vec_idx) || vec_idx == '0)));

  p_gie_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> !gie);

  p_ack_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> ($countones({irq_ack, rst_ack}) == 1));

  p_ack_hot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, rst_ack}));

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_restore && !(vec_valid && vec_ready)) |=> gie);

  p_gie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !vec_valid) |=> (!vec_valid || vec_idx == '0));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_lock && (pc >= BOOT_START) && !vec_valid) |=> (!vec_valid || vec_idx == '0));
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .PC_W(PC_W), .BOOT_START(BOOT_START), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gie_restore(gie_restore), .boot_lock(boot_lock),
  .pc(pc), .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_idx(vec_idx),
  .irq_ack(irq_ack), .rst_ack(rst_ack), .gie(gie)
);

// File: tb/irq_vector_arbiter_bench.sv
module irq_vector_arbiter_bench;
  localparam int N = 4;
  localparam int PW = 8;
  localparam logic [PW-1:0] BASE = 8'h04;
  localparam logic [PW-1:0] BSTART = 8'hC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [N-1:0] irq_en = '0;
  logic gie_restore = 1'b0;
  logic boot_lock = 1'b0;
  logic [PW-1:0] pc = '0;
  logic vec_ready = 1'b0;
  logic vec_valid;
  logic [2:0] vec_idx;
  logic [PW-1:0] vec_addr;
  logic [N-1:0] irq_ack;
  logic rst_ack;
  logic gie;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_arbiter #(.NUM_SRC(N), .PC_W(PW), .VEC_BASE(BASE), .BOOT_START(BSTART))
  u_irq_vector_arbiter (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .irq_req(irq_req),
    .irq_en(irq_en), .gie_restore(gie_restore), .boot_lock(boot_lock), .pc(pc),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_idx(vec_idx),
    .vec_addr(vec_addr), .irq_ack(irq_ack), .rst_ack(rst_ack), .gie(gie)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reset_req = 1'b0; irq_req = '0; irq_en = '0;
    gie_restore = 1'b0; boot_lock = 1'b0; pc = '0; vec_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic restore_pulse();
    gie_restore = 1'b1;
    @(negedge clk);
    gie_restore = 1'b0;
  endtask

  task automatic expect_offer(input string req, input int slot);
    chk(vec_valid == 1'b1, req, int'(vec_valid), 1);
    chk(int'(vec_idx) == slot, req, int'(vec_idx), slot);
    chk(int'(vec_addr) == int'(BASE) + 2 * slot, {req, "/R4"}, int'(vec_addr), int'(BASE) + 2 * slot);
  endtask

  task automatic accept();
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  function automatic int low_slot(input int bits);
    for (int b = 0; b < N; b++) if (bits[b]) return b + 1;
    return -1;
  endfunction

  initial begin
    // R10: reset state
    do_reset();
    @(negedge clk);
    chk(vec_valid == 1'b0, "R10 valid", int'(vec_valid), 0);
    chk(gie == 1'b0, "R10 gie", int'(gie), 0);
    chk({irq_ack, rst_ack} == '0, "R10 ack", int'({irq_ack, rst_ack}), 0);

    // Sweep: every enable mask against every request pattern.
    for (int en = 0; en < 16; en++) begin
      for (int pat = 0; pat < 16; pat++) begin
        int act_bits;
        int s1;
        int s2;
        do_reset();
        irq_en = N'(en);
        restore_pulse();
        chk(gie == 1'b1, "R9 restore", int'(gie), 1);
        irq_req = N'(pat);
        act_bits = en & pat;
        s1 = low_slot(act_bits);
        @(negedge clk);
        chk(vec_valid == 1'b0, "R11 not after one edge", int'(vec_valid), 0);
        @(negedge clk);
        if (s1 < 0) begin
          chk(vec_valid == 1'b0, "R2 masked no offer", int'(vec_valid), 0);
        end else begin
          expect_offer("R3 R11 first winner", s1);
          repeat (2) @(negedge clk);
          expect_offer("R7 stall holds", s1);
          accept();
          chk(int'(irq_ack) == (1 << (s1 - 1)), "R8 ack line", int'(irq_ack), 1 << (s1 - 1));
          chk(gie == 1'b0, "R8 gie cleared", int'(gie), 0);
          chk(vec_valid == 1'b0, "R8 valid drops", int'(vec_valid), 0);
          @(negedge clk);
          chk(irq_ack == '0, "R8 ack one cycle", int'(irq_ack), 0);
          repeat (2) @(negedge clk);
          chk(vec_valid == 1'b0, "R2 gie off no offer", int'(vec_valid), 0);
          restore_pulse();
          repeat (2) @(negedge clk);
          s2 = low_slot(act_bits & ~(1 << (s1 - 1)));
          if (s2 < 0) chk(vec_valid == 1'b0, "R1 no retrigger on held level", int'(vec_valid), 0);
          else expect_offer("R1 R3 runner-up", s2);
        end
      end
    end

    // R5: reset bypasses gie, enables and lock
    do_reset();
    boot_lock = 1'b1; pc = 8'hFF; reset_req = 1'b1;
    repeat (2) @(negedge clk);
    expect_offer("R5 reset unmasked", 0);
    accept();
    chk(rst_ack == 1'b1, "R5 rst_ack", int'(rst_ack), 1);

    // R5: reset preempts a stalled interrupt offer
    do_reset();
    irq_en = '1;
    restore_pulse();
    irq_req = 4'b0100;
    repeat (3) @(negedge clk);
    expect_offer("R5 before preempt", 3);
    reset_req = 1'b1;
    repeat (2) @(negedge clk);
    expect_offer("R5 preempted", 0);
    accept();
    chk(rst_ack == 1'b1 && irq_ack == '0, "R5 reset acked", int'({irq_ack, rst_ack}), 1);
    restore_pulse();
    repeat (2) @(negedge clk);
    expect_offer("R1 pending kept after preempt", 3);

    // R6: lock at and below the boundary
    do_reset();
    irq_en = '1; boot_lock = 1'b1; pc = BSTART;
    restore_pulse();
    irq_req = 4'b0001;
    repeat (4) @(negedge clk);
    chk(vec_valid == 1'b0, "R6 locked at boot start", int'(vec_valid), 0);
    pc = BSTART - 8'd1;
    repeat (2) @(negedge clk);
    expect_offer("R6 unlocked below boot start", 1);
    do_reset();
    irq_en = '1; boot_lock = 1'b0; pc = 8'hFF;
    restore_pulse();
    irq_req = 4'b0010;
    repeat (3) @(negedge clk);
    expect_offer("R6 no lock high pc", 2);

    // R1: short pulse on a masked line is kept
    do_reset();
    restore_pulse();
    irq_req = 4'b0010;
    @(negedge clk);
    irq_req = '0;
    repeat (3) @(negedge clk);
    chk(vec_valid == 1'b0, "R1 masked pulse not offered", int'(vec_valid), 0);
    irq_en = 4'b0010;
    repeat (2) @(negedge clk);
    expect_offer("R1 masked pulse kept", 2);

    finish_run();
  end
endmodule